// File: doc/BRIEF.md
# Prioritized Interrupt Vector Generator

This block sits between a set of interrupt-raising peripherals and a processor core. Each peripheral raises a one-cycle set strobe, which the block latches as a pending flag. A flag is eligible when its own enable bit and the block's global enable are both 1. When the core is not already being served and some source is eligible, the block picks the eligible source with the lowest index. It then raises a registered request and presents that source's program-memory vector address.

Vectors are two words apart. The non-maskable reset request owns address 0x000. Source index i owns address 2*(i+1). Indices 0 to 2 are the three external request pins. Indices 3 to 13 are, in order:

- timer2 compare and timer2 overflow
- timer1 capture, timer1 compare A, timer1 compare B and timer1 overflow
- timer0 compare and timer0 overflow
- serial transfer complete
- receive complete on the two UARTs

Indices 14 to 19 are the remaining sources. The lower the index, the higher the priority.

The request and vector are held steady until the core acknowledges. The acknowledge clears the served flag and drops the global enable in the same clock. A return strobe from the core sets the global enable back to 1. The core can also write the global enable directly.

Top module: `irqVecGen`

## Requirements
- R1: After `rstN` is released, `intReq`=0, `intVec`=0, `gie`=0 and `pending`=0.
- R2: A 1 on `irqSet[i]` at a clock edge makes `pending[i]`=1 from that edge on. The flag stays 1 until it is cleared by an acknowledge of source i.
- R3: Source i can raise a request only while `pending[i]`=1, `irqEn[i]`=1 and `gie`=1. With `gie`=0, or with the source's enable bit 0, no request rises from idle.
- R4: When several sources are eligible, the lowest index wins. The presented vector is 2*(i+1): index 0 gives 0x002, index 2 gives 0x006, and index 19 gives 0x028.
- R5: `intReq` and `intVec` are registered. A source that becomes eligible at one edge is requested at the next edge, so a set strobe leads to a request two edges later.
- R6: While `intReq`=1 and no acknowledge or reset request is present, `intReq` and `intVec` keep their values. This holds even when higher-priority flags arrive or when enables change.
- R7: `intAck`=1 while `intReq`=1 makes the following values appear at the next edge: `intReq`=0, `gie`=0, and the served source's pending flag 0. All other flags are unchanged. `intAck` while `intReq`=0 has no effect.
- R8: If the served source's `irqSet` bit is 1 in the same cycle as its acknowledge, its pending flag stays 1.
- R9: The global enable updates in this order of precedence:
  - `resetReq` or an accepted acknowledge forces `gie` to 0.
  - Otherwise, `intRet`=1 sets `gie` to 1.
  - Otherwise, `gieWe`=1 loads `gieWd`.
- R10: `resetReq`=1 makes the next edge give `intReq`=1 and `intVec`=0x000, whatever the enables, `gie` or any held vector. It also clears `gie` and leaves the pending flags unchanged. The reset vector is held until it is acknowledged, and that acknowledge clears no pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqSet | input | 20 | Per-source set strobes from peripherals, bit i is source i |
| irqEn | input | 20 | Per-source enable mask |
| resetReq | input | 1 | Non-maskable reset request, vector 0x000 |
| intAck | input | 1 | Core accepts the presented vector |
| intRet | input | 1 | Core returned from an interrupt handler, restores global enable |
| gieWe | input | 1 | Direct write strobe for the global enable |
| gieWd | input | 1 | Value for the direct global-enable write |
| intReq | output | 1 | Registered request to the core |
| intVec | output | 16 | Registered program-memory vector address |
| gie | output | 1 | Global interrupt enable state |
| pending | output | 20 | Pending flags, bit i is source i |

## Verification
The hardest situations to reach from the ports are collisions. One kind is a higher-priority flag arriving while a lower-priority vector is held. Another is an acknowledge landing in the same cycle as a new set strobe for the served source, a return strobe or a reset request. Directed sequences build each collision on purpose and check it against explicit expected values. A long run from a fixed-seed `$urandom` stream follows. In that run acknowledges, returns, global-enable writes and reset requests are drawn at independent rates. Every output is compared each cycle with a bench model built from the requirements.

// File: rtl/irqvec_pkg.sv
package irqvec_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadVec;    // capture winner into request/vector registers
    logic loadReset;  // present the reset vector
    logic dropReq;    // end the current request
    logic clearSel;   // clear the pending flag of the held source
  } vecCtrl_t;
endpackage

// File: rtl/irqVecDatapath.sv
module irqVecDatapath
  import irqvec_pkg::*;
#(
  parameter int NUM_SRC  = 20,
  parameter int ADDR_W   = 16,
  parameter int VEC_STEP = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqSet,
  input  logic [NUM_SRC-1:0] irqEn,
  input  logic               gieIn,
  input  vecCtrl_t           ctrl,
  output logic               anyEligible,
  output logic               intReq,
  output logic [ADDR_W-1:0]  intVec,
  output logic [NUM_SRC-1:0] pending
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] eligible;
  logic [IDX_W-1:0]   winIdx;
  logic [IDX_W-1:0]   selIdx;

  function automatic logic [ADDR_W-1:0] vecOf(input logic [IDX_W-1:0] idx);
    return ADDR_W'((int'(idx) + 1) * VEC_STEP);
  endfunction

  // pending flag per source; a new set beats a same-cycle clear
  for (genvar i = 0; i < NUM_SRC; i++) begin : gPend
    logic clrBit;
    assign clrBit = ctrl.clearSel && (selIdx == IDX_W'(i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            pending[i] <= 1'b0;
      else if (irqSet[i])   pending[i] <= 1'b1;
      else if (clrBit)      pending[i] <= 1'b0;
    end
  end

  assign eligible    = pending & irqEn & {NUM_SRC{gieIn}};
  assign anyEligible = |eligible;

  // fixed priority: lowest index wins
  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i]) winIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intReq <= 1'b0;
      intVec <= '0;
      selIdx <= '0;
    end else if (ctrl.loadReset) begin
      intReq <= 1'b1;
      intVec <= '0;
    end else if (ctrl.dropReq) begin
      intReq <= 1'b0;
    end else if (ctrl.loadVec) begin
      intReq <= 1'b1;
      intVec <= vecOf(winIdx);
      selIdx <= winIdx;
    end
  end

  // R4: any presented vector sits on the 2-word grid inside the table
  assert_vec_in_table_R4: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (intVec % ADDR_W'(VEC_STEP) == '0) && (intVec <= ADDR_W'(VEC_STEP * NUM_SRC)));

  // R2: a set strobe is visible as a pending flag after the edge
  assert_set_latched_R2: assert property (@(posedge clk) disable iff (!rstN)
    (irqSet != '0) |=> ((pending & $past(irqSet)) == $past(irqSet)));
endmodule

// File: rtl/irqVecControl.sv
module irqVecControl
  import irqvec_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     resetReq,
  input  logic     intAck,
  input  logic     intRet,
  input  logic     gieWe,
  input  logic     gieWd,
  input  logic     anyEligible,
  input  logic     reqHeld,
  output vecCtrl_t ctrl,
  output logic     gie
);
  logic holdIsReset;
  logic ackTaken;

  assign ackTaken = reqHeld && intAck && !resetReq;

  always_comb begin
    ctrl = '0;
    if (resetReq) begin
      ctrl.loadReset = 1'b1;
    end else if (reqHeld) begin
      if (intAck) begin
        ctrl.dropReq  = 1'b1;
        ctrl.clearSel = !holdIsReset;
      end
    end else if (anyEligible) begin
      ctrl.loadVec = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gie         <= 1'b0;
      holdIsReset <= 1'b0;
    end else begin
      if (resetReq || ackTaken) gie <= 1'b0;
      else if (intRet)          gie <= 1'b1;
      else if (gieWe)           gie <= gieWd;

      if (resetReq)          holdIsReset <= 1'b1;
      else if (ctrl.loadVec) holdIsReset <= 1'b0;
    end
  end

  // R9: a return strobe restores the global enable unless overridden
  assert_ret_sets_gie_R9: assert property (@(posedge clk) disable iff (!rstN)
    (intRet && !resetReq && !(reqHeld && intAck)) |=> gie);

  // R7: an accepted acknowledge drops the global enable
  assert_ack_clears_gie_R7: assert property (@(posedge clk) disable iff (!rstN)
    ackTaken |=> !gie);
endmodule

// File: rtl/irqVecGen.sv
module irqVecGen
  import irqvec_pkg::*;
#(
  parameter int NUM_SRC  = 20,
  parameter int ADDR_W   = 16,
  parameter int VEC_STEP = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqSet,
  input  logic [NUM_SRC-1:0] irqEn,
  input  logic               resetReq,
  input  logic               intAck,
  input  logic               intRet,
  input  logic               gieWe,
  input  logic               gieWd,
  output logic               intReq,
  output logic [ADDR_W-1:0]  intVec,
  output logic               gie,
  output logic [NUM_SRC-1:0] pending
);
  vecCtrl_t ctrl;
  logic     anyEligible;

  irqVecControl uCtrl (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .intAck(intAck),
    .intRet(intRet), .gieWe(gieWe), .gieWd(gieWd),
    .anyEligible(anyEligible), .reqHeld(intReq), .ctrl(ctrl), .gie(gie)
  );

  irqVecDatapath #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .VEC_STEP(VEC_STEP)) uDp (
    .clk(clk), .rstN(rstN), .irqSet(irqSet), .irqEn(irqEn), .gieIn(gie),
    .ctrl(ctrl), .anyEligible(anyEligible), .intReq(intReq),
    .intVec(intVec), .pending(pending)
  );

  // R6: a held request and its vector do not move until acknowledged
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && !intAck && !resetReq) |=> (intReq && $stable(intVec)));

  // R7: acknowledge ends the request
  assert_ack_drops_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && intAck && !resetReq) |=> !intReq);

  // R10: reset request always wins with vector zero
  assert_reset_vector_R10: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> (intReq && intVec == '0 && !gie));

  // R3: nothing is requested from idle while the global enable is off
  assert_no_req_without_gie_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!intReq && !resetReq && !gie) |=> !intReq);
endmodule

// File: tb/tb_irqVecGen.sv
`timescale 1ns/1ps
module tb_irqVecGen;
  localparam int N = 20;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] irqSet = '0, irqEn = '0;
  logic resetReq = 0, intAck = 0, intRet = 0, gieWe = 0, gieWd = 0;
  logic intReq, gie;
  logic [AW-1:0] intVec;
  logic [N-1:0] pending;

  int checks = 0, failures = 0;

  // bench model state
  logic [N-1:0] mPend;
  logic mGie, mReq, mHR;
  logic [AW-1:0] mVec;
  int mSel;

  irqVecGen dut (
    .clk(clk), .rstN(rstN), .irqSet(irqSet), .irqEn(irqEn), .resetReq(resetReq),
    .intAck(intAck), .intRet(intRet), .gieWe(gieWe), .gieWd(gieWd),
    .intReq(intReq), .intVec(intVec), .gie(gie), .pending(pending)
  );

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [AW-1:0] expVec(input int idx);
    return AW'(2 * (idx + 1));
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic modelStep();
    logic [N-1:0] clr, elig;
    logic nGie, nReq, nHR;
    logic [AW-1:0] nVec;
    int nSel;
    clr = '0; nGie = mGie; nReq = mReq; nHR = mHR; nVec = mVec; nSel = mSel;
    if (resetReq) begin
      nReq = 1; nVec = '0; nHR = 1; nGie = 0;
    end else begin
      if (mReq && intAck) begin
        nReq = 0; nGie = 0;
        if (!mHR) clr[mSel] = 1'b1;
      end else begin
        if (intRet) nGie = 1;
        else if (gieWe) nGie = gieWd;
        if (!mReq) begin
          elig = mPend & irqEn & {N{mGie}};
          for (int i = N - 1; i >= 0; i--)
            if (elig[i]) begin nSel = i; nReq = 1; nVec = expVec(i); nHR = 0; end
        end
      end
    end
    mPend = irqSet | (mPend & ~clr);
    mGie = nGie; mReq = nReq; mHR = nHR; mVec = nVec; mSel = nSel;
  endtask

  // one clock with current inputs, then compare all outputs with the model
  task automatic cyc(input string tag);
    modelStep();
    @(posedge clk); #1;
    chk(tag, "intReq", 32'(intReq), 32'(mReq));
    chk(tag, "intVec", 32'(intVec), 32'(mVec));
    chk(tag, "gie", 32'(gie), 32'(mGie));
    chk(tag, "pending", 32'(pending), 32'(mPend));
    irqSet = '0; intAck = 0; intRet = 0; gieWe = 0; resetReq = 0;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mPend = '0; mGie = 0; mReq = 0; mHR = 0; mVec = '0; mSel = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "intReq", 32'(intReq), 0);
    chk("R1", "intVec", 32'(intVec), 0);
    chk("R1", "gie", 32'(gie), 0);
    chk("R1", "pending", 32'(pending), 0);

    // R3: pending + enabled but gie=0 -> no request
    irqEn = '1; irqSet = 20'h00010; cyc("R2");
    chk("R2", "pending4", 32'(pending[4]), 1);
    cyc("R3"); cyc("R3");
    chk("R3", "noReqGie0", 32'(intReq), 0);

    // R9: direct write enables gie; R5 timing
    gieWe = 1; gieWd = 1; cyc("R9");
    chk("R9", "gieWrite", 32'(gie), 1);
    chk("R5", "notYet", 32'(intReq), 0);
    cyc("R5");
    chk("R5", "reqRise", 32'(intReq), 1);
    chk("R4", "vecIdx4", 32'(intVec), 32'h00a);

    // R6: higher priority arrives while held
    irqSet = 20'h00001; cyc("R6");
    cyc("R6");
    chk("R6", "heldVec", 32'(intVec), 32'h00a);
    irqEn = '0; cyc("R6");
    chk("R6", "heldReq", 32'(intReq), 1);
    irqEn = '1;

    // R7: acknowledge
    intAck = 1; cyc("R7");
    chk("R7", "reqDrop", 32'(intReq), 0);
    chk("R7", "gieOff", 32'(gie), 0);
    chk("R7", "pendCleared", 32'(pending), 32'h00001);
    intAck = 1; cyc("R7");  // ack while idle ignored
    chk("R7", "ackIdle", 32'(pending), 32'h00001);

    // R9: return restores gie, beats write
    intRet = 1; gieWe = 1; gieWd = 0; cyc("R9");
    chk("R9", "retWins", 32'(gie), 1);
    cyc("R4");
    chk("R4", "vecIdx0", 32'(intVec), 32'h002);

    // R8: set and ack same cycle for served source
    intAck = 1; irqSet = 20'h00001; cyc("R8");
    chk("R8", "setBeatsClr", 32'(pending[0]), 1);
    intAck = 1; intRet = 1; cyc("R9");  // ack beats ret: ignored since req=0? idle
    intRet = 1; cyc("R9");
    cyc("R4");
    intAck = 1; cyc("R7");

    // R4: lowest of several, then index 19
    irqEn = '1; intRet = 1; irqSet = 20'h80024; cyc("R4");
    cyc("R4");
    chk("R4", "vecIdx2", 32'(intVec), 32'h006);
    intAck = 1; cyc("R4"); intRet = 1; cyc("R4"); cyc("R4");
    chk("R4", "vecIdx5", 32'(intVec), 32'h00c);
    intAck = 1; cyc("R4"); intRet = 1; cyc("R4"); cyc("R4");
    chk("R4", "vecIdx19", 32'(intVec), 32'h028);

    // R3: per-source enable masks
    intAck = 1; cyc("R3"); irqEn = '0; irqSet = 20'h00008; intRet = 1; cyc("R3");
    cyc("R3");
    chk("R3", "maskedNoReq", 32'(intReq), 0);

    // R10: reset request overrides a held vector
    irqEn = '1; cyc("R10");
    chk("R10", "heldIdx3", 32'(intVec), 32'h008);
    resetReq = 1; cyc("R10");
    chk("R10", "resetVec", 32'(intVec), 0);
    chk("R10", "resetReq", 32'(intReq), 1);
    chk("R10", "pendKept", 32'(pending[3]), 1);
    intAck = 1; cyc("R10");
    chk("R10", "noFlagClr", 32'(pending[3]), 1);

    // random phase
    void'($urandom(32'd2024));
    for (int k = 0; k < 3000; k++) begin
      irqSet   = (($urandom % 4) == 0) ? N'($urandom) & N'($urandom) : '0;
      irqEn    = N'($urandom) | N'($urandom);
      intAck   = intReq && (($urandom % 3) == 0);
      if (($urandom % 9) == 0) intAck = 1;
      intRet   = ($urandom % 5) == 0;
      gieWe    = ($urandom % 7) == 0;
      gieWd    = 1'($urandom);
      resetReq = ($urandom % 60) == 0;
      cyc("R6");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule